// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O controller that sits on a simple register port. The port has an address, a write strobe and write data, and it returns read data in the same cycle. Software reads the pad levels through a data register. It changes the output latch through a set register and a clear register, where each register writes ones to change only the selected lines. It chooses which lines drive their pads through two direction registers, and the block always keeps these two registers bitwise complementary. The block drives one output value and one output enable per line toward the pads, and it samples the pad inputs through a two-flop synchroniser.

The register width is fixed at elaboration to 8, 16, 32 or 64 bits, and the number of lines equals that width. A build option reverses the line-to-bit mapping, so that line 0 sits at the most significant bit of every register. A second build option removes the clear register. In that build a write to the set register loads the whole output latch. Reading the set register returns the latched output values, so software can compare driven levels with the pad levels it reads from the data register.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: While reset is low and after it is released, the output latch and every output enable are zero. The output-direction register (address 3) reads 0, and the input-direction register (address 4) reads all ones.
- R2: A read of address 0 returns the pad levels. A pad change applied before clock edge k appears in the read data after edge k+1, not earlier.
- R3: A write to address 1 in the build with a clear register sets every line whose bit is 1 and leaves the other lines unchanged.
- R4: A write to address 2 clears every line whose bit is 1 and leaves the other lines unchanged.
- R5: In the build without a clear register, a write to address 1 loads the output latch, so a 0 bit drives the line low. A write to address 2 has no effect, and address 2 reads 0.
- R6: A write to address 3 makes each line with a 1 bit an output, by setting its output enable, and each line with a 0 bit an input.
- R7: A write to address 4 makes each line with a 1 bit an input and each line with a 0 bit an output.
- R8: A read of address 4 always returns the bitwise complement of a read of address 3.
- R9: With mirrored order enabled, line n corresponds to bit (width-1-n) in every register, both on writes and on reads.
- R10: A read of address 1 returns the current output latch.
- R11: A write changes the output values and enables on the clock edge that ends the write cycle. In a cycle without a write, the outputs stay unchanged. Addresses 5 to 7 ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the register port |
| busAddr | input | 3 | Register address |
| busWrData | input | REG_WIDTH | Write data |
| busRdData | output | REG_WIDTH | Read data for busAddr, valid in the same cycle |
| padIn | input | REG_WIDTH | Pad input levels, asynchronous to clk |
| padOut | output | REG_WIDTH | Output value per line |
| padOe | output | REG_WIDTH | Output enable per line, 1 = drive |

## Verification
A register write is presented for one cycle, and its effect on padOut and padOe is due on the following rising edge. The bench therefore drives inputs on the falling edge and samples on the next falling edge. Read data is combinational from the stored state, so each read is sampled shortly after its address is applied. A pad change takes two rising edges to reach the data register. The bench checks the old value one falling edge after the change and the new value one edge later, which shows both the latency and that the value does not arrive early.

// File: rtl/mmio_gpio_pkg.sv
package mmio_gpio_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_DATA   = 3'd0,
    ADDR_SET    = 3'd1,
    ADDR_CLR    = 3'd2,
    ADDR_DIROUT = 3'd3,
    ADDR_DIRIN  = 3'd4
  } regAddr_e;

  typedef struct packed {
    logic wrSet;     // OR write data into the output latch
    logic wrClr;     // clear written ones in the output latch
    logic loadOut;   // load the output latch outright
    logic wrDirOut;  // load the enables from the data
    logic wrDirIn;   // load the enables from the inverted data
  } ctrlStrobe_t;

endpackage

// File: rtl/mmio_gpio_ctrl_decode.sv
module mmio_gpio_ctrl_decode
  import mmio_gpio_pkg::*;
#(
  parameter bit HAS_CLEAR = 1'b1
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);

  always_comb begin
    strobe = '0;
    if (busWrEn) begin
      case (busAddr)
        ADDR_SET: begin
          if (HAS_CLEAR) strobe.wrSet   = 1'b1;
          else           strobe.loadOut = 1'b1;
        end
        ADDR_CLR:    strobe.wrClr    = HAS_CLEAR;
        ADDR_DIROUT: strobe.wrDirOut = 1'b1;
        ADDR_DIRIN:  strobe.wrDirIn  = 1'b1;
        default:     strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/mmio_gpio_datapath.sv
module mmio_gpio_datapath
  import mmio_gpio_pkg::*;
#(
  parameter int REG_WIDTH    = 32,
  parameter bit MIRROR_ORDER = 1'b0,
  parameter bit HAS_CLEAR    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [REG_WIDTH-1:0] wrData,
  output logic [REG_WIDTH-1:0] rdData,
  input  logic [REG_WIDTH-1:0] padIn,
  output logic [REG_WIDTH-1:0] padOut,
  output logic [REG_WIDTH-1:0] padOe
);

  localparam int LAST = REG_WIDTH - 1;

  logic [REG_WIDTH-1:0] wrLines;
  logic [REG_WIDTH-1:0] syncStage1, syncStage2;
  logic [REG_WIDTH-1:0] outLatch, oeLatch;
  logic [REG_WIDTH-1:0] dataBus, latchBus, oeBus;

  // The mapping between lines and register bits is chosen once, here.
  genvar gi;
  generate
    for (gi = 0; gi < REG_WIDTH; gi++) begin : g_map
      localparam int BIT = MIRROR_ORDER ? (LAST - gi) : gi;
      assign wrLines[gi]   = wrData[BIT];
      assign dataBus[BIT]  = syncStage2[gi];
      assign latchBus[BIT] = outLatch[gi];
      assign oeBus[BIT]    = oeLatch[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage1 <= '0;
      syncStage2 <= '0;
    end else begin
      syncStage1 <= padIn;
      syncStage2 <= syncStage1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
    end else if (strobe.loadOut) begin
      outLatch <= wrLines;
    end else if (strobe.wrSet) begin
      outLatch <= outLatch | wrLines;
    end else if (strobe.wrClr) begin
      outLatch <= outLatch & ~wrLines;
    end
  end

  // A single enable vector holds both direction registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeLatch <= '0;
    end else if (strobe.wrDirOut) begin
      oeLatch <= wrLines;
    end else if (strobe.wrDirIn) begin
      oeLatch <= ~wrLines;
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_DATA:   rdData = dataBus;
      ADDR_SET:    rdData = latchBus;
      ADDR_DIROUT: rdData = oeBus;
      ADDR_DIRIN:  rdData = ~oeBus;
      default:     rdData = '0;
    endcase
  end

  assign padOut = outLatch;
  assign padOe  = oeLatch;

endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
  import mmio_gpio_pkg::*;
#(
  parameter int REG_WIDTH    = 32,
  parameter bit MIRROR_ORDER = 1'b0,
  parameter bit HAS_CLEAR    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [REG_WIDTH-1:0] busWrData,
  output logic [REG_WIDTH-1:0] busRdData,
  input  logic [REG_WIDTH-1:0] padIn,
  output logic [REG_WIDTH-1:0] padOut,
  output logic [REG_WIDTH-1:0] padOe
);

  ctrlStrobe_t strobe;

  mmio_gpio_ctrl_decode #(
    .HAS_CLEAR(HAS_CLEAR)
  ) u_decode (
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  mmio_gpio_datapath #(
    .REG_WIDTH   (REG_WIDTH),
    .MIRROR_ORDER(MIRROR_ORDER),
    .HAS_CLEAR   (HAS_CLEAR)
  ) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .rdAddr(busAddr),
    .wrData(busWrData),
    .rdData(busRdData),
    .padIn (padIn),
    .padOut(padOut),
    .padOe (padOe)
  );

endmodule

// File: rtl/mmio_gpio_ctrl_checker.sv
module mmio_gpio_ctrl_checker
  import mmio_gpio_pkg::*;
#(
  parameter int REG_WIDTH    = 32,
  parameter bit MIRROR_ORDER = 1'b0,
  parameter bit HAS_CLEAR    = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWrEn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [REG_WIDTH-1:0] busWrData,
  input logic [REG_WIDTH-1:0] busRdData,
  input logic [REG_WIDTH-1:0] padOut,
  input logic [REG_WIDTH-1:0] padOe
);

  logic [REG_WIDTH-1:0] lines, oeBus;

  genvar gi;
  generate
    for (gi = 0; gi < REG_WIDTH; gi++) begin : g_map
      localparam int BIT = MIRROR_ORDER ? (REG_WIDTH - 1 - gi) : gi;
      assign lines[gi]  = busWrData[BIT];
      assign oeBus[BIT] = padOe[gi];
    end
  endgenerate

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |-> (padOut == '0 && padOe == '0));

  generate
    if (HAS_CLEAR) begin : g_clr
      assert_set_R3: assert property (@(posedge clk) disable iff (!rstN)
        busWrEn && busAddr == ADDR_SET |=>
          ((padOut & $past(lines)) == $past(lines)) &&
          (((padOut ^ $past(padOut)) & ~$past(lines)) == '0));
      assert_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
        busWrEn && busAddr == ADDR_CLR |=>
          ((padOut & $past(lines)) == '0) &&
          (((padOut ^ $past(padOut)) & ~$past(lines)) == '0));
    end else begin : g_noclr
      assert_load_R5: assert property (@(posedge clk) disable iff (!rstN)
        busWrEn && busAddr == ADDR_SET |=> padOut == $past(lines));
      assert_clrignored_R5: assert property (@(posedge clk) disable iff (!rstN)
        busWrEn && busAddr == ADDR_CLR |=> $stable(padOut));
    end
  endgenerate

  assert_dirout_R6: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == ADDR_DIROUT |=> padOe == $past(lines));

  assert_dirin_R7: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == ADDR_DIRIN |=> padOe == ~$past(lines));

  assert_dirout_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == ADDR_DIROUT |-> busRdData == oeBus);

  assert_dirin_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == ADDR_DIRIN |-> busRdData == ~oeBus);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(padOut) && $stable(padOe));

endmodule

bind mmio_gpio_ctrl mmio_gpio_ctrl_checker #(
  .REG_WIDTH   (REG_WIDTH),
  .MIRROR_ORDER(MIRROR_ORDER),
  .HAS_CLEAR   (HAS_CLEAR)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .padOut   (padOut),
  .padOe    (padOe)
);

// File: tb/mmio_gpio_ctrl_bench.sv
module mmio_gpio_ctrl_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Main instance: 32 lines, natural order, with clear register
  logic        mWrEn = 1'b0;
  logic [2:0]  mAddr = 3'd0;
  logic [31:0] mWrData = '0, mRdData, mPadIn = '0, mPadOut, mPadOe;

  // Second instance: 8 lines, mirrored, no clear register
  logic        aWrEn = 1'b0;
  logic [2:0]  aAddr = 3'd0;
  logic [7:0]  aWrData = '0, aRdData, aPadIn = '0, aPadOut, aPadOe;

  mmio_gpio_ctrl #(.REG_WIDTH(32), .MIRROR_ORDER(1'b0), .HAS_CLEAR(1'b1)) u_mmio_gpio_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(mWrEn), .busAddr(mAddr), .busWrData(mWrData),
    .busRdData(mRdData), .padIn(mPadIn), .padOut(mPadOut), .padOe(mPadOe));

  mmio_gpio_ctrl #(.REG_WIDTH(8), .MIRROR_ORDER(1'b1), .HAS_CLEAR(1'b0)) u_mmio_gpio_ctrl_mirror (
    .clk(clk), .rstN(rstN), .busWrEn(aWrEn), .busAddr(aAddr), .busWrData(aWrData),
    .busRdData(aRdData), .padIn(aPadIn), .padOut(aPadOut), .padOe(aPadOe));

  int checks = 0;
  int failures = 0;
  logic [31:0] expOut = '0, expOe = '0;

  function automatic logic [7:0] rev8(input logic [7:0] x);
    for (int i = 0; i < 8; i++) rev8[i] = x[7-i];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mWrite(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    mWrEn = 1'b1; mAddr = addr; mWrData = data;
    @(negedge clk);
    mWrEn = 1'b0;
  endtask

  task automatic mRead(input logic [2:0] addr, output logic [31:0] data);
    mAddr = addr;
    #1;
    data = mRdData;
  endtask

  task automatic aWrite(input logic [2:0] addr, input logic [7:0] data);
    @(negedge clk);
    aWrEn = 1'b1; aAddr = addr; aWrData = data;
    @(negedge clk);
    aWrEn = 1'b0;
  endtask

  task automatic aRead(input logic [2:0] addr, output logic [7:0] data);
    aAddr = addr;
    #1;
    data = aRdData;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  ard;
    logic [31:0] newPad;
    void'($urandom(32'h5eed_0042));

    // R1: reset state, while reset is low
    repeat (3) @(negedge clk);
    check(mPadOut == '0 && mPadOe == '0, "R1 reset outputs", {mPadOut, mPadOe}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    mRead(3'd3, rd); check(rd == 32'h0, "R1 dirout after reset", rd, 32'h0);
    mRead(3'd4, rd); check(rd == 32'hFFFF_FFFF, "R1 dirin after reset", rd, 32'hFFFF_FFFF);
    mRead(3'd1, rd); check(rd == 32'h0, "R1 R10 latch after reset", rd, 32'h0);
    aRead(3'd4, ard); check(ard == 8'hFF, "R1 dirin after reset (8-bit)", ard, 8'hFF);

    // R3 / R4 directed corners
    mWrite(3'd1, 32'hA5A5_0001); expOut = 32'hA5A5_0001;
    check(mPadOut == expOut, "R3 set directed", mPadOut, expOut);
    mWrite(3'd1, 32'h0); check(mPadOut == expOut, "R3 zero set no change", mPadOut, expOut);
    mWrite(3'd2, 32'h0); check(mPadOut == expOut, "R4 zero clear no change", mPadOut, expOut);
    mWrite(3'd2, 32'h8000_0001); expOut = 32'h25A5_0000;
    check(mPadOut == expOut, "R4 clear directed", mPadOut, expOut);

    // R11: unused addresses ignore writes and read zero
    mWrite(3'd6, 32'hFFFF_FFFF);
    check(mPadOut == expOut && mPadOe == expOe, "R11 unused write ignored", mPadOut, expOut);
    mRead(3'd7, rd); check(rd == 32'h0, "R11 unused read zero", rd, 32'h0);

    // Random mix of writes with a bench model
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] d;
      op = $urandom % 5;
      d  = $urandom;
      case (op)
        0: begin mWrite(3'd1, d); expOut = expOut | d;  end
        1: begin mWrite(3'd2, d); expOut = expOut & ~d; end
        2: begin mWrite(3'd3, d); expOe  = d;           end
        3: begin mWrite(3'd4, d); expOe  = ~d;          end
        default: mWrite(3'd5 + 3'(d[0]), d);
      endcase
      check(mPadOut == expOut, "R3 R4 R11 random outputs", mPadOut, expOut);
      check(mPadOe == expOe, "R6 R7 random enables", mPadOe, expOe);
      if (it % 8 == 0) begin
        mRead(3'd1, rd); check(rd == expOut, "R10 latch readback", rd, expOut);
        mRead(3'd3, rd); check(rd == expOe, "R6 dirout readback", rd, expOe);
        mRead(3'd4, rd); check(rd == ~expOe, "R8 dirin complement", rd, ~expOe);
      end
    end

    // R2: pad input latency through two flops
    for (int k = 0; k < 6; k++) begin
      logic [31:0] oldPad;
      @(negedge clk);
      mAddr = 3'd0;
      #1 oldPad = mRdData;
      newPad = $urandom;
      mPadIn = newPad;
      @(negedge clk);
      mRead(3'd0, rd); check(rd == oldPad, "R2 not visible after one edge", rd, oldPad);
      @(negedge clk);
      mRead(3'd0, rd); check(rd == newPad, "R2 visible after two edges", rd, newPad);
    end

    // R5 / R9 on the mirrored build without a clear register
    aWrite(3'd1, 8'h01);
    check(aPadOut == 8'h80, "R9 R5 mirrored set loads", aPadOut, 8'h80);
    aWrite(3'd1, 8'h0F);
    check(aPadOut == rev8(8'h0F), "R5 load drives zeros low", aPadOut, rev8(8'h0F));
    aWrite(3'd2, 8'hFF);
    check(aPadOut == 8'hF0, "R5 clear address ignored", aPadOut, 8'hF0);
    aRead(3'd2, ard); check(ard == 8'h00, "R5 clear address reads zero", ard, 8'h00);
    aRead(3'd1, ard); check(ard == 8'h0F, "R10 R9 mirrored latch readback", ard, 8'h0F);
    aWrite(3'd3, 8'h03);
    check(aPadOe == 8'hC0, "R9 R6 mirrored dirout", aPadOe, 8'hC0);
    aWrite(3'd4, 8'h01);
    check(aPadOe == 8'h7F, "R9 R7 mirrored dirin", aPadOe, 8'h7F);
    aRead(3'd3, ard); check(ard == 8'hFE, "R8 mirrored dirout read", ard, 8'hFE);
    @(negedge clk);
    aPadIn = 8'h01;
    repeat (2) @(negedge clk);
    aRead(3'd0, ard); check(ard == 8'h80, "R9 R2 mirrored data read", ard, 8'h80);
    aWrite(3'd1, 8'h00);
    check(aPadOut == 8'h00, "R5 load all zero", aPadOut, 8'h00);

    finishRun();
  end

endmodule